// File: doc/BRIEF.md
# Write-Burst Interrupt Rule Checker

A passive, cycle-accurate monitor for a DDR2-class command bus. It watches the decoded command stream and reports two classes of protocol misuse. The first class covers illegal attempts to cut a write burst short. The only legal cut is made by a second write that arrives exactly two clocks after a non-auto-precharge write while the mode burst length is eight. The second class covers a precharge issued to a bank before the write recovery spacing has elapsed. That spacing is always measured against the full programmed burst, even when the burst was truncated.

The monitor also reports, for every clock, which write owns the data beats on the DQ lines and which beat pair is being transferred. A bench can use this to check that the four leading beats of an interrupted write run straight into all eight beats of the interrupting write. Write latency, write recovery and burst length come in as static configuration inputs. Nothing on the bus is altered.

Top module: `wr_intr_checker`

## Requirements
- R1: While rst_ni is low and after its release, viol_o is 0, viol_code_o is 0 and own_o is 0. All burst and per-bank tracking is cleared, so the first write after reset is never an interrupt and a precharge straight after reset is never early.
- R2: Commands use cmd_i encoding NOP=0, ACT=1, RD=2, WR=3, PRE=4. Every write, legal or not, opens an interrupt window that covers command cycles 1 to BL/2-1 after it. Within that window an RD, WR or PRE is an interrupt attempt. NOP and ACT never cause a violation, and a WR at offset BL/2 or later is not an interrupt.
- R3: An interrupt attempt is legal, and raises no violation, when bl8_i=1, the open write had no auto precharge, the command is WR and the offset is exactly 2. The new write may target any bank.
- R4: An interrupt attempt while bl8_i=0 (burst of four) is reported with code 1.
- R5: An RD or PRE inside the window of an eight-beat write is reported with code 2.
- R6: A WR inside the window of an eight-beat write at an offset other than 2 is reported with code 3.
- R7: Any interrupt attempt on a write that carried auto precharge is reported with code 4. This code has the highest priority, followed by codes 1, 2 and 3. A legal interrupting write may itself carry auto precharge.
- R8: A PRE to a bank fewer than wl_i + BL/2 + twr_i clocks after the last WR to that bank is reported with code 5. BL is the programmed length even when that WR was interrupted. Code 5 is used only when no window code applies.
- R9: viol_o and viol_code_o are registered. They are valid in the clock after the offending command and last one clock per offending command. viol_code_o is 0 whenever viol_o is 0.
- R10: A write's data starts wl_i clocks after its command. own_o then shows 1 for a normal write or 2 for a legal interrupting write, and pair_o counts 0 up to BL/2-1, where pair p carries beats 2p and 2p+1. A later write's data start replaces the running one. own_o is 0 when no data is due.
- R11: wl_i may be set from 1 to 15, and the data start moves with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command (NOP/ACT/RD/WR/PRE) |
| bank_i | input | 3 | Target bank |
| ap_i | input | 1 | Auto precharge flag for WR |
| bl8_i | input | 1 | Mode burst length: 1 = eight, 0 = four |
| wl_i | input | 4 | Write latency in clocks |
| twr_i | input | 4 | Write recovery in clocks |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 3 | Violation code, 0 when none |
| own_o | output | 2 | Data owner: 0 idle, 1 normal, 2 interrupting |
| pair_o | output | 2 | Beat pair index within the owning burst |

## Verification
A violation for a command presented in cycle n is due in cycle n+1. The bench drives each command on a falling edge and reads viol_o and viol_code_o on the next falling edge. Data ownership for a write issued in cycle n first shows in cycle n+wl_i. The bench therefore reads own_o and pair_o once per falling edge after the write and compares each reading against a trace worked out from wl_i and the burst length. Precharge spacing is probed one clock below and exactly at the limit, for both an intact and a truncated burst.

// File: rtl/wic_pkg.sv
package wic_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_ACT = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3, CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE = 3'd0, V_BL4 = 3'd1, V_CMD = 3'd2, V_OFS = 3'd3, V_AP = 3'd4, V_PRE = 3'd5
  } viol_e;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0, OWN_FIRST = 2'd1, OWN_INTR = 2'd2
  } own_e;
endpackage

// File: rtl/wic_window.sv
module wic_window
  import wic_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cmd_e  cmd_i,
  input  logic  ap_i,
  input  logic  bl8_i,
  output viol_e code_o,
  output logic  legal_int_o
);
  logic       act_q, ap_q;
  logic [2:0] age_q;
  logic [2:0] half;
  logic       in_win, attempt;

  assign half    = bl8_i ? 3'd4 : 3'd2;
  assign in_win  = act_q && (age_q < half);
  assign attempt = in_win && (cmd_i == CMD_WR || cmd_i == CMD_RD || cmd_i == CMD_PRE);

  always_comb begin
    code_o = V_NONE;
    if (attempt) begin
      if (ap_q)                code_o = V_AP;
      else if (!bl8_i)         code_o = V_BL4;
      else if (cmd_i != CMD_WR) code_o = V_CMD;
      else if (age_q != 3'd2)  code_o = V_OFS;
    end
  end

  assign legal_int_o = attempt && (code_o == V_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ap_q  <= 1'b0;
      age_q <= 3'd0;
    end else if (cmd_i == CMD_WR) begin
      act_q <= 1'b1;
      ap_q  <= ap_i;
      age_q <= 3'd1;
    end else if (act_q && age_q != 3'd4) begin
      age_q <= age_q + 3'd1;
    end
  end

  // R3
  legal_past_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_int_o |-> $past(cmd_i == CMD_WR, 2));
endmodule

// File: rtl/wic_bank_timer.sv
module wic_bank_timer
  import wic_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int WL_W      = 4,
  parameter int TWR_W     = 4,
  parameter int CNT_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              bl8_i,
  input  logic [WL_W-1:0]   wl_i,
  input  logic [TWR_W-1:0]  twr_i,
  output logic              early_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] limit;
  logic [NUM_BANKS-1:0] early_b;

  assign limit = CNT_W'(wl_i) + (bl8_i ? CNT_W'(4) : CNT_W'(2)) + CNT_W'(twr_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             act_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit        = (bank_i == BANK_W'(b));
    assign early_b[b] = hit && (cmd_i == CMD_PRE) && act_q && (cnt_q < limit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (hit && cmd_i == CMD_WR) begin
        act_q <= 1'b1;
        cnt_q <= CNT_W'(1);
      end else if (act_q && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign early_o = |early_b;
endmodule

// File: rtl/wic_beat_sched.sv
module wic_beat_sched
  import wic_pkg::*;
#(
  parameter int WL_MAX = 15,
  localparam int WL_W  = $clog2(WL_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            intr_i,
  input  logic            bl8_i,
  input  logic [WL_W-1:0] wl_i,
  output own_e            own_o,
  output logic [1:0]      pair_o
);
  logic [WL_MAX-1:0] hv_q, ht_q;
  logic [WL_W-1:0]   tap;
  logic              start;
  own_e              tag;
  logic              eng_act_q;
  own_e              eng_own_q;
  logic [1:0]        eng_pair_q;
  logic [1:0]        last;

  assign tap   = wl_i - WL_W'(1);
  assign start = (wl_i != '0) && (int'(wl_i) <= WL_MAX) && hv_q[tap];
  assign tag   = ht_q[tap] ? OWN_INTR : OWN_FIRST;
  assign last  = bl8_i ? 2'd3 : 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q <= '0;
      ht_q <= '0;
    end else begin
      hv_q <= {hv_q[WL_MAX-2:0], wr_i};
      ht_q <= {ht_q[WL_MAX-2:0], intr_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_act_q  <= 1'b0;
      eng_own_q  <= OWN_IDLE;
      eng_pair_q <= 2'd0;
    end else if (start) begin
      eng_act_q  <= 1'b1;
      eng_own_q  <= tag;
      eng_pair_q <= 2'd1;
    end else if (eng_act_q) begin
      if (eng_pair_q >= last) eng_act_q <= 1'b0;
      else                    eng_pair_q <= eng_pair_q + 2'd1;
    end
  end

  always_comb begin
    if (start) begin
      own_o  = tag;
      pair_o = 2'd0;
    end else if (eng_act_q) begin
      own_o  = eng_own_q;
      pair_o = eng_pair_q;
    end else begin
      own_o  = OWN_IDLE;
      pair_o = 2'd0;
    end
  end

  // R10
  intr_takeover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && tag == OWN_INTR) |-> (eng_act_q && eng_pair_q == 2'd2));
endmodule

// File: rtl/wr_intr_checker.sv
module wr_intr_checker
  import wic_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int WL_MAX    = 15,
  parameter int TWR_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int WL_W     = $clog2(WL_MAX + 1),
  localparam int LIM_MAX  = WL_MAX + 4 + (1 << TWR_W) - 1,
  localparam int CNT_W    = $clog2(LIM_MAX + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  input  logic              bl8_i,
  input  logic [WL_W-1:0]   wl_i,
  input  logic [TWR_W-1:0]  twr_i,
  output logic              viol_o,
  output logic [2:0]        viol_code_o,
  output logic [1:0]        own_o,
  output logic [1:0]        pair_o
);
  cmd_e  cmd;
  viol_e win_code, code_d;
  logic  legal_int, early;
  own_e  own;

  assign cmd = cmd_e'(cmd_i);

  wic_window u_win (
    .clk_i, .rst_ni, .cmd_i(cmd), .ap_i, .bl8_i,
    .code_o(win_code), .legal_int_o(legal_int)
  );

  wic_bank_timer #(
    .NUM_BANKS(NUM_BANKS), .WL_W(WL_W), .TWR_W(TWR_W), .CNT_W(CNT_W)
  ) u_tmr (
    .clk_i, .rst_ni, .cmd_i(cmd), .bank_i, .bl8_i, .wl_i, .twr_i, .early_o(early)
  );

  wic_beat_sched #(.WL_MAX(WL_MAX)) u_beat (
    .clk_i, .rst_ni, .wr_i(cmd == CMD_WR), .intr_i(legal_int), .bl8_i, .wl_i,
    .own_o(own), .pair_o
  );

  assign own_o  = own;
  assign code_d = (win_code != V_NONE) ? win_code : (early ? V_PRE : V_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_code_o <= 3'd0;
    end else begin
      viol_o      <= (code_d != V_NONE);
      viol_code_o <= code_d;
    end
  end

  // R2
  nop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP || cmd_i == CMD_ACT) |=> !viol_o);

  // R8
  pre_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && viol_code_o == V_PRE) |-> $past(cmd_i) == CMD_PRE);

  // R9
  code_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !viol_o |-> (viol_code_o == 3'd0));
endmodule

// File: tb/sim_wr_intr_checker.sv
`timescale 1ns/1ps
module sim_wr_intr_checker;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [2:0] bank = 3'd0;
  logic       ap = 1'b0;
  logic       bl8 = 1'b1;
  logic [3:0] wl = 4'd2;
  logic [3:0] twr = 4'd3;
  logic       viol;
  logic [2:0] vcode;
  logic [1:0] own, pair;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_intr_checker u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap),
    .bl8_i(bl8), .wl_i(wl), .twr_i(twr), .viol_o(viol), .viol_code_o(vcode),
    .own_o(own), .pair_o(pair)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input logic a);
    cmd = c; bank = 3'(b); ap = a;
    @(negedge clk);
    cmd = NOP; ap = 1'b0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 1'b0);
  endtask

  task automatic expect_v(input string req, input int code);
    chk(req, viol, code != 0);
    chk(req, vcode, code);
  endtask

  task automatic t_reset;
    chk("R1 viol", viol, 0);
    chk("R1 code", vcode, 0);
    chk("R1 own", own, 0);
    rst_n = 1'b1;
    step(PRE, 0, 1'b0);
    expect_v("R1 pre after reset", 0);
  endtask

  // A at c0 bank0, B at c2 bank1; owner trace with WL=2
  task automatic t_legal;
    int eo[9] = '{0, 0, 1, 1, 2, 2, 2, 2, 0};
    int ep[9] = '{0, 0, 0, 1, 0, 1, 2, 3, 0};
    bl8 = 1; wl = 2;
    step(WR, 0, 1'b0);
    chk("R10 own c1", own, eo[1]);
    step(NOP, 0, 1'b0);
    expect_v("R2 nop", 0);
    chk("R10 own c2", own, eo[2]); chk("R10 pair c2", pair, ep[2]);
    step(WR, 1, 1'b0);
    expect_v("R3 legal other bank", 0);
    chk("R10 own c3", own, eo[3]); chk("R10 pair c3", pair, ep[3]);
    for (int c = 4; c <= 8; c++) begin
      step(NOP, 0, 1'b0);
      chk("R10 own trace", own, eo[c]);
      chk("R10 pair trace", pair, ep[c]);
    end
    nops(40);
  endtask

  task automatic t_bl4;
    bl8 = 0;
    step(WR, 2, 1'b0);
    step(WR, 2, 1'b0);
    expect_v("R4 bl4 write", 1);
    step(RD, 2, 1'b0);
    expect_v("R4 bl4 read", 1);
    nops(40);
    bl8 = 1;
  endtask

  task automatic t_cmd;
    step(WR, 4, 1'b0); step(NOP, 0, 1'b0);
    step(RD, 4, 1'b0);
    expect_v("R5 read in window", 2);
    nops(6);
    step(WR, 5, 1'b0);
    step(PRE, 6, 1'b0);
    expect_v("R5 pre in window", 2);
    nops(6);
    step(WR, 5, 1'b0); step(ACT, 6, 1'b0);
    expect_v("R2 act ignored", 0);
    nops(40);
  endtask

  task automatic t_ofs;
    step(WR, 0, 1'b0);
    step(WR, 0, 1'b0);
    expect_v("R6 offset 1", 3);
    nops(6);
    step(WR, 1, 1'b0); nops(2);
    step(WR, 1, 1'b0);
    expect_v("R6 offset 3", 3);
    nops(6);
    step(WR, 2, 1'b0); nops(3);
    step(WR, 2, 1'b0);
    expect_v("R2 offset 4 seamless", 0);
    nops(40);
  endtask

  task automatic t_ap;
    step(WR, 3, 1'b1); step(NOP, 0, 1'b0);
    step(WR, 3, 1'b0);
    expect_v("R7 ap interrupted", 4);
    nops(6);
    bl8 = 0;
    step(WR, 3, 1'b1);
    step(RD, 3, 1'b0);
    expect_v("R7 ap priority over bl4", 4);
    bl8 = 1;
    nops(6);
    step(WR, 0, 1'b0); step(NOP, 0, 1'b0);
    step(WR, 1, 1'b1);
    expect_v("R7 interrupter with ap", 0);
    step(NOP, 0, 1'b0);
    step(WR, 2, 1'b0);
    expect_v("R7 interrupt of ap interrupter", 4);
    nops(40);
  endtask

  // limit = wl 2 + 4 + twr 3 = 9
  task automatic t_pre;
    step(WR, 2, 1'b0); nops(7);
    step(PRE, 2, 1'b0);
    expect_v("R8 pre at 8", 5);
    nops(40);
    step(WR, 2, 1'b0); nops(8);
    step(PRE, 2, 1'b0);
    expect_v("R8 pre at 9", 0);
    nops(40);
    step(WR, 3, 1'b0); step(NOP, 0, 1'b0);
    step(WR, 4, 1'b0); nops(5);
    step(PRE, 3, 1'b0);
    expect_v("R8 truncated pre at 8", 5);
    step(PRE, 3, 1'b0);
    expect_v("R8 truncated pre at 9", 0);
    step(PRE, 7, 1'b0);
    expect_v("R8 unwritten bank", 0);
    nops(40);
  endtask

  task automatic t_wl;
    wl = 4;
    step(WR, 0, 1'b0);
    nops(2);
    chk("R11 own c3", own, 0);
    step(NOP, 0, 1'b0);
    chk("R11 own c4", own, 1); chk("R11 pair c4", pair, 0);
    nops(3);
    chk("R11 pair c7", pair, 3);
    step(NOP, 0, 1'b0);
    chk("R11 own c8", own, 0);
    wl = 2;
    nops(40);
  endtask

  task automatic t_midreset;
    step(WR, 1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 own in reset", own, 0);
    rst_n = 1'b1;
    step(PRE, 1, 1'b0);
    expect_v("R1 pre after midreset", 0);
    step(WR, 1, 1'b0);
    expect_v("R1 first write after reset", 0);
    nops(40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_legal();
    t_bl4();
    t_cmd();
    t_ofs();
    t_ap();
    t_pre();
    t_wl();
    t_midreset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule